// File: doc/BRIEF.md
# Gapless Segment Ensemble Averager

This block takes one stream of samples, each tagged with a channel number, and cuts every channel's samples into consecutive segments of a fixed length. No sample falls between two segments. The sample at each segment position is summed across a run of segments, and the number of segments in a run is selected at run time. During the last segment of a run the block emits the averaged value for each position as that position's sample arrives. The averaged segment therefore leaves in sample order, tagged with its channel, and the final position carries a segment-done flag.

The input is never stalled and there is no ready signal. Each sample is accepted on the clock edge where it is presented, and the next run on that channel begins with the very next sample. Every channel keeps its own position counter, segment counter and latched run length, so channels may be interleaved in any order. One accumulator word is held per channel and per position. The first segment of a run writes that word, and later segments add to it.

Top module: `seg_ens_avg`

## Requirements
- R1: After reset, out_valid and out_last are low, and the first accepted sample of each channel goes to position 0 of segment 0 of a new run.
- R2: Every accepted sample of a channel advances that channel's position by one. After position SEG_LEN-1 the position wraps to 0 and the next segment begins, so no sample is skipped or repeated.
- R3: For the first segment of a run, the stored value at a position becomes the sample itself. For later segments, the sample is added to the stored value.
- R4: The output value is the sum of the navg samples at one position, divided by navg and truncated toward zero. It never overflows DW signed bits.
- R5: An output is produced only for samples of the last segment of a run. It appears with out_valid high for one cycle, at the second rising edge after the edge that accepted that sample.
- R6: out_ch equals the sample's channel tag, and out_last is high only with the output for position SEG_LEN-1.
- R7: With a run length of 1, every accepted sample is output unchanged.
- R8: cfg_navg is sampled per channel only on the first sample of a run, and changes during a run are ignored until the next run. A value of 0 is treated as 1, and values above MAX_AVG are treated as MAX_AVG.
- R9: Channels are independent: interleaving samples of different channels in any order, with idle cycles, gives each channel the same results as an uninterrupted stream.
- R10: A new run starts on the sample right after the last sample of the previous run, with no idle cycle needed.
- R11: A sample whose tag is NUM_CH or higher is ignored. It produces no output and changes no channel's state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample present this cycle |
| in_ch | input | CHW | Channel tag of the sample |
| in_data | input | DW | Signed sample |
| cfg_navg | input | NW | Number of segments per run, sampled at run start |
| out_valid | output | 1 | Averaged sample present |
| out_ch | output | CHW | Channel tag of the averaged sample |
| out_data | output | DW | Signed averaged sample |
| out_last | output | 1 | Marks the last position of the averaged segment |

## Verification
The assertions check the following on every cycle:
- the selected position and segment counters stay in range;
- the latched run length stays between 1 and MAX_AVG;
- each final-segment sample leads to an output two edges later, carrying its tag and the correct out_last;
- out_last never appears without out_valid;
- with a run length of 1, the output equals the input.

The numeric averages, the cut-off of a mid-run configuration change, clamping, rejection of out-of-range tags and independence under random interleaving can only be shown by the bench. It compares every output cycle against a model that accumulates and divides on its own.

// File: rtl/seg_ens_avg_pkg.sv
package seg_ens_avg_pkg;

  // Rounded-up reciprocal 2^rs / n, used for non power-of-two divisors
  function automatic logic [63:0] recip_of(int n, int rs);
    if (n <= 0) return 64'd0;
    return ((64'd1 << rs) + 64'(n) - 64'd1) / 64'(n);
  endfunction

  function automatic logic is_pow2(logic [15:0] n);
    return (n != 16'd0) && ((n & (n - 16'd1)) == 16'd0);
  endfunction

  function automatic logic [4:0] log2_of(logic [15:0] n);
    logic [4:0] r;
    r = 5'd0;
    for (int i = 0; i < 16; i++)
      if (n[i]) r = 5'(i);
    return r;
  endfunction

endpackage

// File: rtl/seg_ens_avg_chan.sv
// Per-channel position, segment and run-length bookkeeping
module seg_ens_avg_chan #(
  parameter int SEG_LEN = 32,
  parameter int MAX_AVG = 128,
  parameter int PW      = $clog2(SEG_LEN),
  parameter int NW      = $clog2(MAX_AVG + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit,
  input  logic [NW-1:0] cfg,
  output logic [PW-1:0] pos,
  output logic [NW-1:0] seg,
  output logic [NW-1:0] navg_eff,
  output logic          first_seg,
  output logic          last_seg,
  output logic          last_pos
);

  logic [NW-1:0] navg_lat;
  logic [NW-1:0] cfg_clamped;
  logic          at_start;

  always_comb begin
    if (cfg == '0)                   cfg_clamped = NW'(1);
    else if (cfg > NW'(MAX_AVG))     cfg_clamped = NW'(MAX_AVG);
    else                             cfg_clamped = cfg;
  end

  assign at_start  = (pos == '0) && (seg == '0);
  assign navg_eff  = at_start ? cfg_clamped : navg_lat;
  assign first_seg = (seg == '0);
  assign last_seg  = (seg == navg_eff - NW'(1));
  assign last_pos  = (pos == PW'(SEG_LEN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos      <= '0;
      seg      <= '0;
      navg_lat <= NW'(1);
    end else if (hit) begin
      if (at_start) navg_lat <= cfg_clamped;
      if (last_pos) begin
        pos <= '0;
        seg <= last_seg ? '0 : seg + NW'(1);
      end else begin
        pos <= pos + PW'(1);
      end
    end
  end

endmodule

// File: rtl/seg_ens_avg_acc.sv
// Accumulator store: one sum per channel and position
module seg_ens_avg_acc #(
  parameter int DEPTH = 128,
  parameter int AW    = $clog2(DEPTH),
  parameter int DW    = 16,
  parameter int SUMW  = 23
) (
  input  logic                   clk,
  input  logic                   we,
  input  logic [AW-1:0]          addr,
  input  logic                   first,
  input  logic signed [DW-1:0]   sample,
  output logic signed [SUMW-1:0] sum_new
);

  logic signed [SUMW-1:0] mem [DEPTH];
  logic signed [SUMW-1:0] ext;

  assign ext     = {{(SUMW-DW){sample[DW-1]}}, sample};
  assign sum_new = first ? ext : mem[addr] + ext;

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= sum_new;
  end

endmodule

// File: rtl/seg_ens_avg_div.sv
// Two-stage divide: capture, then shift or reciprocal multiply on the magnitude
module seg_ens_avg_div #(
  parameter int DW      = 16,
  parameter int SUMW    = 23,
  parameter int MAX_AVG = 128,
  parameter int NW      = $clog2(MAX_AVG + 1),
  parameter int CHW     = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_v,
  input  logic signed [SUMW-1:0] in_sum,
  input  logic [NW-1:0]          in_navg,
  input  logic [CHW-1:0]         in_ch,
  input  logic                   in_last,
  output logic                   out_valid,
  output logic [CHW-1:0]         out_ch,
  output logic signed [DW-1:0]   out_data,
  output logic                   out_last
);
  import seg_ens_avg_pkg::*;

  localparam int RS = SUMW + $clog2(MAX_AVG) + 2;
  localparam int RW = RS + 1;

  logic [RW-1:0] recip_rom [MAX_AVG+1];
  for (genvar g = 0; g <= MAX_AVG; g++) begin : g_rom
    assign recip_rom[g] = RW'(recip_of(g, RS));
  end

  logic                   s_v, s_last;
  logic signed [SUMW-1:0] s_sum;
  logic [NW-1:0]          s_navg;
  logic [CHW-1:0]         s_ch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_v <= 1'b0; s_last <= 1'b0; s_sum <= '0; s_navg <= NW'(1); s_ch <= '0;
    end else begin
      s_v    <= in_v;
      s_last <= in_v && in_last;
      if (in_v) begin
        s_sum <= in_sum; s_navg <= in_navg; s_ch <= in_ch;
      end
    end
  end

  logic                   neg;
  logic [SUMW-1:0]        mag, q_shift, q;
  logic [SUMW+RW-1:0]     prod;
  logic                   p2;
  logic [4:0]             sh;
  logic signed [SUMW-1:0] res;

  always_comb begin
    neg     = s_sum[SUMW-1];
    mag     = neg ? SUMW'(-s_sum) : SUMW'(s_sum);
    p2      = is_pow2(16'(s_navg));
    sh      = log2_of(16'(s_navg));
    q_shift = mag >> sh;
    prod    = {{RW{1'b0}}, mag} * {{SUMW{1'b0}}, recip_rom[s_navg]};
    q       = p2 ? q_shift : prod[RS +: SUMW];
    res     = neg ? -$signed(q) : $signed(q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0; out_last <= 1'b0; out_ch <= '0; out_data <= '0;
    end else begin
      out_valid <= s_v;
      out_last  <= s_last;
      if (s_v) begin
        out_ch   <= s_ch;
        out_data <= res[DW-1:0];
      end
    end
  end

endmodule

// File: rtl/seg_ens_avg.sv
module seg_ens_avg #(
  parameter int NUM_CH  = 4,
  parameter int SEG_LEN = 32,
  parameter int MAX_AVG = 128,
  parameter int DW      = 16,
  parameter int CHW     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  parameter int NW      = $clog2(MAX_AVG + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [CHW-1:0]       in_ch,
  input  logic signed [DW-1:0] in_data,
  input  logic [NW-1:0]        cfg_navg,
  output logic                 out_valid,
  output logic [CHW-1:0]       out_ch,
  output logic signed [DW-1:0] out_data,
  output logic                 out_last
);

  localparam int PW    = $clog2(SEG_LEN);
  localparam int SUMW  = DW + $clog2(MAX_AVG);
  localparam int DEPTH = NUM_CH * SEG_LEN;
  localparam int AW    = $clog2(DEPTH);

  logic [PW-1:0] pos_a   [NUM_CH];
  logic [NW-1:0] seg_a   [NUM_CH];
  logic [NW-1:0] navg_a  [NUM_CH];
  logic          first_a [NUM_CH];
  logic          lseg_a  [NUM_CH];
  logic          lpos_a  [NUM_CH];

  // Named internal events used by the checker
  logic          ch_ok, ev_in, ev_final;
  logic [CHW-1:0] sel_idx;
  logic [PW-1:0] sel_pos;
  logic [NW-1:0] sel_seg, sel_navg;
  logic          sel_first, sel_last_seg, sel_last_pos;

  assign ch_ok   = (32'(in_ch) < NUM_CH);
  assign ev_in   = in_valid && ch_ok;
  assign sel_idx = ch_ok ? in_ch : '0;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    seg_ens_avg_chan #(.SEG_LEN(SEG_LEN), .MAX_AVG(MAX_AVG), .PW(PW), .NW(NW)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .hit       (ev_in && (32'(in_ch) == c)),
      .cfg       (cfg_navg),
      .pos       (pos_a[c]),
      .seg       (seg_a[c]),
      .navg_eff  (navg_a[c]),
      .first_seg (first_a[c]),
      .last_seg  (lseg_a[c]),
      .last_pos  (lpos_a[c])
    );
  end

  assign sel_pos      = pos_a[sel_idx];
  assign sel_seg      = seg_a[sel_idx];
  assign sel_navg     = navg_a[sel_idx];
  assign sel_first    = first_a[sel_idx];
  assign sel_last_seg = lseg_a[sel_idx];
  assign sel_last_pos = lpos_a[sel_idx];
  assign ev_final     = ev_in && sel_last_seg;

  logic [AW-1:0]          addr;
  logic signed [SUMW-1:0] sum_new;

  assign addr = AW'(sel_idx) * AW'(SEG_LEN) + AW'(sel_pos);

  seg_ens_avg_acc #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .SUMW(SUMW)) u_acc (
    .clk     (clk),
    .we      (ev_in),
    .addr    (addr),
    .first   (sel_first),
    .sample  (in_data),
    .sum_new (sum_new)
  );

  seg_ens_avg_div #(.DW(DW), .SUMW(SUMW), .MAX_AVG(MAX_AVG), .NW(NW), .CHW(CHW)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_v      (ev_final),
    .in_sum    (sum_new),
    .in_navg   (sel_navg),
    .in_ch     (sel_idx),
    .in_last   (sel_last_pos),
    .out_valid (out_valid),
    .out_ch    (out_ch),
    .out_data  (out_data),
    .out_last  (out_last)
  );

endmodule

// File: rtl/seg_ens_avg_chk.sv
module seg_ens_avg_chk #(
  parameter int SEG_LEN = 32,
  parameter int MAX_AVG = 128,
  parameter int DW      = 16,
  parameter int CHW     = 2,
  parameter int NW      = 8,
  parameter int PW      = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ev_in,
  input logic                 ev_final,
  input logic [PW-1:0]        sel_pos,
  input logic [NW-1:0]        sel_seg,
  input logic [NW-1:0]        sel_navg,
  input logic                 sel_last_pos,
  input logic [CHW-1:0]       in_ch,
  input logic signed [DW-1:0] in_data,
  input logic                 out_valid,
  input logic [CHW-1:0]       out_ch,
  input logic signed [DW-1:0] out_data,
  input logic                 out_last
);

  a_r2_pos_range: assert property (@(posedge clk) disable iff (!rst_n)
    32'(sel_pos) < SEG_LEN);

  a_r8_navg_range: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_navg >= NW'(1)) && (32'(sel_navg) <= MAX_AVG));

  a_r8_seg_range: assert property (@(posedge clk) disable iff (!rst_n)
    sel_seg < sel_navg);

  a_r5_final_latency: assert property (@(posedge clk) disable iff (!rst_n)
    ev_final |-> ##2 out_valid);

  a_r6_last_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_final && sel_last_pos) |-> ##2 (out_valid && out_last));

  a_r6_ch_echo: assert property (@(posedge clk) disable iff (!rst_n)
    ev_final |-> ##2 (out_ch == $past(in_ch, 2)));

  a_r6_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  a_r7_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_in && sel_navg == NW'(1)) |-> ##2 (out_valid && out_data == $past(in_data, 2)));

endmodule

bind seg_ens_avg seg_ens_avg_chk #(
  .SEG_LEN(SEG_LEN), .MAX_AVG(MAX_AVG), .DW(DW), .CHW(CHW), .NW(NW), .PW($clog2(SEG_LEN))
) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_in(ev_in), .ev_final(ev_final),
  .sel_pos(sel_pos), .sel_seg(sel_seg), .sel_navg(sel_navg), .sel_last_pos(sel_last_pos),
  .in_ch(in_ch), .in_data(in_data), .out_valid(out_valid), .out_ch(out_ch),
  .out_data(out_data), .out_last(out_last)
);

// File: tb/seg_ens_avg_tb.sv
module seg_ens_avg_tb;
  localparam int NUM_CH = 3, SEG_LEN = 8, MAX_AVG = 8, DW = 16;
  localparam int CHW = 2, NW = 4;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [CHW-1:0] in_ch = '0;
  logic signed [DW-1:0] in_data = '0;
  logic [NW-1:0] cfg_navg = NW'(1);
  logic out_valid, out_last;
  logic [CHW-1:0] out_ch;
  logic signed [DW-1:0] out_data;

  always #10 clk = ~clk;

  seg_ens_avg #(.NUM_CH(NUM_CH), .SEG_LEN(SEG_LEN), .MAX_AVG(MAX_AVG), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ch(in_ch), .in_data(in_data),
    .cfg_navg(cfg_navg), .out_valid(out_valid), .out_ch(out_ch), .out_data(out_data),
    .out_last(out_last)
  );

  int checks = 0, failures = 0, cyc = 0;
  string cur_req = "R1";

  typedef struct { int due; int ch; longint val; bit last; } exp_t;
  exp_t q[$];
  int m_pos[NUM_CH], m_seg[NUM_CH], m_navg[NUM_CH];
  longint m_acc[NUM_CH][SEG_LEN];

  function automatic int clamp_cfg(int c);
    if (c == 0) return 1;
    if (c > MAX_AVG) return MAX_AVG;
    return c;
  endfunction

  // Truncation toward zero, as required by R4
  function automatic longint avg_of(longint s, int n);
    return s / n;
  endfunction

  task automatic check(bit ok, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", cur_req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < NUM_CH; c++) begin
      m_pos[c] = 0; m_seg[c] = 0; m_navg[c] = 1;
    end
    q.delete();
  endtask

  task automatic model_accept(int ch, longint x, int cfg);
    exp_t e;
    if (ch >= NUM_CH) return;                       // R11
    if (m_pos[ch] == 0 && m_seg[ch] == 0) m_navg[ch] = clamp_cfg(cfg);   // R8
    if (m_seg[ch] == 0) m_acc[ch][m_pos[ch]] = x;   // R3
    else m_acc[ch][m_pos[ch]] += x;
    if (m_seg[ch] == m_navg[ch] - 1) begin
      e.due = cyc + 2; e.ch = ch; e.last = (m_pos[ch] == SEG_LEN - 1);
      e.val = avg_of(m_acc[ch][m_pos[ch]], m_navg[ch]);
      q.push_back(e);
    end
    if (m_pos[ch] == SEG_LEN - 1) begin             // R2, R10
      m_pos[ch] = 0;
      m_seg[ch] = (m_seg[ch] == m_navg[ch] - 1) ? 0 : m_seg[ch] + 1;
    end else m_pos[ch]++;
  endtask

  task automatic observe();
    if (q.size() > 0 && q[0].due == cyc) begin
      check(out_valid == 1'b1, "out_valid (R5)", out_valid, 1);
      check(out_data == q[0].val, "out_data (R4)", out_data, q[0].val);
      check(out_ch == q[0].ch, "out_ch (R6)", out_ch, q[0].ch);
      check(out_last == q[0].last, "out_last (R6)", out_last, q[0].last);
      void'(q.pop_front());
    end else begin
      check(out_valid == 1'b0, "idle out_valid (R5)", out_valid, 0);
    end
  endtask

  task automatic tick(bit v, int ch, longint x, int cfg);
    @(negedge clk);
    cyc++;
    observe();
    in_valid = v; in_ch = CHW'(ch); in_data = DW'(x); cfg_navg = NW'(cfg);
    if (v) model_accept(ch, x, cfg);
  endtask

  task automatic do_reset();
    repeat (3) tick(0, 0, 0, 1);
    @(negedge clk); cyc++;
    rst_n = 1'b0; in_valid = 1'b0;
    @(negedge clk); cyc++;
    cur_req = "R1";
    check(out_valid == 1'b0, "reset out_valid", out_valid, 0);
    check(out_last == 1'b0, "reset out_last", out_last, 0);
    model_reset();
    rst_n = 1'b1;
  endtask

  function automatic longint rnd_sample();
    int r = $urandom_range(0, 9);
    if (r == 0) return -32768;
    if (r == 1) return 32767;
    return longint'($signed(16'($urandom)));
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (2) @(negedge clk);
    cyc = 2;
    do_reset();

    // R7: run length 1 is pass-through
    cur_req = "R7";
    for (int i = 0; i < 2 * SEG_LEN; i++) tick(1, 0, rnd_sample(), 1);

    // R4, R3, R10: four-segment runs back to back, with an all-minimum run
    cur_req = "R4";
    for (int i = 0; i < 4 * SEG_LEN; i++) tick(1, 1, rnd_sample(), 4);
    for (int i = 0; i < 4 * SEG_LEN; i++) tick(1, 1, -32768, 4);
    cur_req = "R10";
    for (int i = 0; i < 3 * SEG_LEN; i++) tick(1, 1, rnd_sample(), 3);   // non power of two

    // R8: change mid-run ignored; 0 taken as 1; above maximum clamped
    do_reset();
    cur_req = "R8";
    tick(1, 0, 1000, 3);
    for (int i = 1; i < 3 * SEG_LEN; i++) tick(1, 0, rnd_sample(), 6);
    for (int i = 0; i < 6 * SEG_LEN; i++) tick(1, 0, rnd_sample(), 6);
    for (int i = 0; i < SEG_LEN; i++) tick(1, 2, rnd_sample(), 0);
    for (int i = 0; i < MAX_AVG * SEG_LEN; i++) tick(1, 2, 32767 - i, 15);

    // R11: out-of-range tag ignored during a channel 0 run
    do_reset();
    cur_req = "R11";
    for (int i = 0; i < 2 * SEG_LEN; i++) begin
      tick(1, 0, rnd_sample(), 2);
      tick(1, 3, 30000, 1);
    end

    // R9, R2: random interleaving with idle cycles and random configuration
    do_reset();
    cur_req = "R9";
    for (int i = 0; i < 2500; i++) begin
      if ($urandom_range(0, 4) == 0) tick(0, 0, 0, 1);
      else tick(1, $urandom_range(0, NUM_CH), rnd_sample(), $urandom_range(0, 15));
    end

    repeat (4) tick(0, 0, 0, 1);
    cur_req = "R5";
    check(q.size() == 0, "pending outputs", q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog %s actual=timeout expected=done", cur_req);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule